// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

This block keeps a running total in an accumulator register and adds one operand word to it per word time, one bit position per clock. A single full adder serves every bit position. Its carry is parked in one flip-flop between bit times. The accumulator and an operand register both shift right, least significant bit first. Each new sum bit enters the accumulator at its top end, and each new operand bit enters the operand register at its top end from the serial input.

The two registers are filled on the same clocks, so the block works as a two-stage pipeline. While the operand held in the operand register is being added, the next operand streams in from `ser_in`. Each word is therefore added one word time after it was streamed in. Clearing the block empties both registers, so the first word time after a clear adds zero to zero.

A bit counter marks each word boundary. When a word completes, the block raises a one-cycle done pulse and shows the final carry of that addition on a separate output for the same cycle. Processing advances only on clocks where the enable input is high. Parameter `WIDTH` (default 8) sets the word length.

Top module: `bsa_serial_accum`

## Requirements
- R1: A clock edge with `clr` high sets `acc`, the operand register and the carry to zero, restarts the bit count and drives `word_done` and `carry_out` low on the next cycle. `clr` takes priority over `en`.
- R2: A clock edge with `en` low and `clr` low leaves `acc` unchanged, does not advance the bit count, and is followed by `word_done` low.
- R3: Each clock edge with `en` high shifts `acc` right by one place, so the new `acc[WIDTH-2:0]` equals the old `acc[WIDTH-1:1]`.
- R4: `word_done` is high for exactly one cycle after every `WIDTH`-th enabled edge counted from a clear. It is low after every other enabled edge, and it never stays high for two consecutive cycles.
- R5: In the cycle `word_done` is high, `acc` equals (the value of `acc` at the start of the word plus the operand in the operand register) modulo 2^WIDTH.
- R6: The bit on `ser_in` at the k-th enabled edge of a word (k = 0 first) becomes bit k of the operand added during the following word.
- R7: After a clear, the first word adds zero, so `acc` stays 0. After the second word, `acc` equals the first word streamed in.
- R8: In the cycle `word_done` is high, `carry_out` is 1 exactly when the true sum of that word's addition is at least 2^WIDTH. At all other times `carry_out` is 0.
- R9: The carry is zero at the first bit of every word, so a carry out of one word never enters the next word's sum.
- R10: Pausing `en` for any number of cycles inside a word does not change the sum or the carry produced for that word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear of all state |
| en | input | 1 | Advance one bit position on this clock |
| ser_in | input | 1 | Serial operand bit, least significant first |
| acc | output | WIDTH | Parallel contents of the accumulator |
| word_done | output | 1 | One-cycle pulse after the last bit of a word |
| carry_out | output | 1 | Final carry of the word just finished, valid with `word_done` |

## Verification
Every enabled clock does two jobs at once: it adds the operand register's low bit into the accumulator, and it refills that same register's top bit from `ser_in`. The hazard is that a word streamed in gets mixed into the sum being formed at that moment. The bench feeds words back to back with `en` held high across word boundaries. It uses operands whose bit patterns differ from the ones being added, and it compares `acc` after each word with a reference sum that uses the operand from one word earlier. A second collision falls at the word boundary, where the final carry is reported and the carry register must also be emptied. This case is provoked by an all-ones total followed by zero operands, and the check is that `carry_out` pulses once and the next sum carries nothing over.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
   // Two interchangeable realisations of the single shared full adder
   typedef enum logic [0:0] {
      FA_GATE  = 1'b0,
      FA_ARITH = 1'b1
   } fa_style_e;
endpackage

// File: rtl/bsa_full_adder.sv
module bsa_full_adder
   import bsa_pkg::*;
#(
   parameter fa_style_e STYLE = FA_GATE
) (
   input  logic a,
   input  logic b,
   input  logic ci,
   output logic s,
   output logic co
);
   generate
      if (STYLE == FA_GATE) begin : g_gate
         always_comb begin
            s  = a ^ b ^ ci;
            co = (a & b) | (ci & (a ^ b));
         end
      end else begin : g_arith
         logic [1:0] tot;
         always_comb begin
            tot = {1'b0, a} + {1'b0, b} + {1'b0, ci};
            s   = tot[0];
            co  = tot[1];
         end
      end
   endgenerate

   // R5: sum and carry together encode the count of ones on the inputs
   always_comb begin
      a_fa_count_r5: assert ({co, s} == (2'(a) + 2'(b) + 2'(ci)));
   end
endmodule

// File: rtl/bsa_shift_reg.sv
module bsa_shift_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             en,
   input  logic             din,
   output logic [WIDTH-1:0] q,
   output logic             lsb
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("bsa_shift_reg: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] q_r;

   always_ff @(posedge clk) begin
      if (clr)
         q_r <= '0;
      else if (en)
         q_r <= {din, q_r[WIDTH-1:1]};
   end

   assign q   = q_r;
   assign lsb = q_r[0];

   p_clear_r1: assert property (@(posedge clk) clr |=> (q == '0));

   p_shift_r3: assert property (@(posedge clk) disable iff (clr)
      en |=> (q[WIDTH-2:0] == $past(q[WIDTH-1:1])));

   p_entry_r6: assert property (@(posedge clk) disable iff (clr)
      en |=> (q[WIDTH-1] == $past(din)));

   p_hold_r2: assert property (@(posedge clk) disable iff (clr)
      !en |=> $stable(q));
endmodule

// File: rtl/bsa_bit_counter.sv
module bsa_bit_counter #(
   parameter int WIDTH = 8
) (
   input  logic clk,
   input  logic clr,
   input  logic en,
   output logic first,
   output logic last,
   output logic done
);
   localparam int CNT_W = (WIDTH < 2) ? 1 : $clog2(WIDTH);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIDTH - 1);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("bsa_bit_counter: WIDTH must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             done_q;

   always_ff @(posedge clk) begin
      if (clr) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= en && last;
         if (en)
            cnt_q <= last ? '0 : cnt_q + 1'b1;
      end
   end

   assign first = (cnt_q == '0);
   assign last  = (cnt_q == LAST_IDX);
   assign done  = done_q;

   p_done_pulse_r4: assert property (@(posedge clk) disable iff (clr)
      done |=> !done);

   p_done_clear_r1: assert property (@(posedge clk) clr |=> !done);

   p_idle_r2: assert property (@(posedge clk) disable iff (clr)
      !en |=> (!done && $stable(cnt_q)));

   p_range_r4: assert property (@(posedge clk) disable iff (clr)
      cnt_q <= LAST_IDX);
endmodule

// File: rtl/bsa_serial_accum.sv
module bsa_serial_accum
   import bsa_pkg::*;
#(
   parameter int        WIDTH    = 8,
   parameter fa_style_e FA_STYLE = FA_GATE
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             en,
   input  logic             ser_in,
   output logic [WIDTH-1:0] acc,
   output logic             word_done,
   output logic             carry_out
);
   logic [WIDTH-1:0] opd_q;
   logic             acc_lsb;
   logic             opd_lsb;
   logic             sum_bit;
   logic             fa_co;
   logic             cy_q;
   logic             cout_q;
   logic             first_bit;
   logic             last_bit;

   // Accumulator: sum bit re-enters at the top end
   bsa_shift_reg #(.WIDTH(WIDTH)) u_acc (
      .clk (clk),
      .clr (clr),
      .en  (en),
      .din (sum_bit),
      .q   (acc),
      .lsb (acc_lsb)
   );

   // Operand register: next word streams in while current one is consumed
   bsa_shift_reg #(.WIDTH(WIDTH)) u_opd (
      .clk (clk),
      .clr (clr),
      .en  (en),
      .din (ser_in),
      .q   (opd_q),
      .lsb (opd_lsb)
   );

   bsa_full_adder #(.STYLE(FA_STYLE)) u_fa (
      .a  (acc_lsb),
      .b  (opd_lsb),
      .ci (cy_q),
      .s  (sum_bit),
      .co (fa_co)
   );

   bsa_bit_counter #(.WIDTH(WIDTH)) u_cnt (
      .clk   (clk),
      .clr   (clr),
      .en    (en),
      .first (first_bit),
      .last  (last_bit),
      .done  (word_done)
   );

   // Carry is held one bit time, emptied at the word boundary
   always_ff @(posedge clk) begin
      if (clr) begin
         cy_q   <= 1'b0;
         cout_q <= 1'b0;
      end else if (en) begin
         cy_q   <= last_bit ? 1'b0 : fa_co;
         cout_q <= last_bit ? fa_co : 1'b0;
      end else begin
         cout_q <= 1'b0;
      end
   end

   assign carry_out = cout_q;

   p_cin_zero_r9: assert property (@(posedge clk) disable iff (clr)
      (en && first_bit) |-> (cy_q == 1'b0));

   p_cout_with_done_r8: assert property (@(posedge clk) disable iff (clr)
      carry_out |-> word_done);

   p_clear_flags_r1: assert property (@(posedge clk)
      clr |=> (!carry_out && !word_done && acc == '0));
endmodule

// File: tb/tb_bsa_serial_accum.sv
module tb_bsa_serial_accum;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         clr = 1'b1;
   logic         en = 1'b0;
   logic         ser_in = 1'b0;
   logic [W-1:0] acc;
   logic         word_done;
   logic         carry_out;

   int n_checks = 0;
   int n_fail = 0;

   logic [W-1:0] exp_acc = '0;
   logic [W-1:0] pend_b = '0;
   logic         exp_cy = 1'b0;

   always #2.5 clk = ~clk;

   bsa_serial_accum #(.WIDTH(W)) dut (
      .clk       (clk),
      .clr       (clr),
      .en        (en),
      .ser_in    (ser_in),
      .acc       (acc),
      .word_done (word_done),
      .carry_out (carry_out)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_clear();
      @(negedge clk);
      clr = 1'b1;
      en = 1'b1;
      @(posedge clk);
      #1;
      @(negedge clk);
      clr = 1'b0;
      en = 1'b0;
      exp_acc = '0;
      pend_b = '0;
      exp_cy = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         en = 1'b0;
         ser_in = 1'($urandom);
      end
   endtask

   // Streams one word; optional pause before bit pause_at
   task automatic feed_word(input logic [W-1:0] w, input int pause_at, input string req);
      logic [W:0] tot;
      logic [W-1:0] held;
      for (int i = 0; i < W; i++) begin
         if (i == pause_at) begin
            held = acc;
            for (int p = 0; p < 3; p++) begin
               @(negedge clk);
               en = 1'b0;
               ser_in = 1'($urandom);
               @(posedge clk);
               #1;
               check("R2", "acc during pause", 32'(acc), 32'(held));
               check("R2", "done during pause", 32'(word_done), 32'd0);
            end
         end
         @(negedge clk);
         en = 1'b1;
         ser_in = w[i];
         @(posedge clk);
         #1;
         if (i < W - 1)
            check("R4", "done mid word", 32'(word_done), 32'd0);
      end
      tot = {1'b0, exp_acc} + {1'b0, pend_b};
      exp_acc = tot[W-1:0];
      exp_cy = tot[W];
      pend_b = w;
      check("R4", "done at word end", 32'(word_done), 32'd1);
      check(req, "acc after word", 32'(acc), 32'(exp_acc));
      check("R8", "carry at word end", 32'(carry_out), 32'(exp_cy));
   endtask

   task automatic t_reset();
      do_clear();
      check("R1", "acc after clear", 32'(acc), 32'd0);
      check("R1", "done after clear", 32'(word_done), 32'd0);
      check("R1", "carry after clear", 32'(carry_out), 32'd0);
   endtask

   task automatic t_first_word();
      do_clear();
      feed_word(8'h5A, -1, "R7");
      check("R7", "first word adds zero", 32'(acc), 32'd0);
      feed_word(8'hC3, -1, "R6");
      check("R7", "acc equals first operand", 32'(acc), 32'h5A);
      idle(2);
      check("R8", "carry low when idle", 32'(carry_out), 32'd0);
   endtask

   task automatic t_back_to_back();
      do_clear();
      for (int k = 0; k < 40; k++)
         feed_word(8'($urandom), -1, "R5");
      feed_word(8'h00, -1, "R5");
   endtask

   task automatic t_carry_boundary();
      do_clear();
      feed_word(8'hFF, -1, "R7");
      feed_word(8'h01, -1, "R5");
      check("R5", "acc holds FF", 32'(acc), 32'hFF);
      feed_word(8'h00, -1, "R8");
      check("R8", "wrap to zero", 32'(acc), 32'h00);
      check("R8", "carry set on wrap", 32'(carry_out), 32'd1);
      feed_word(8'h00, -1, "R9");
      check("R9", "no carry leaks", 32'(acc), 32'h00);
      check("R9", "carry cleared", 32'(carry_out), 32'd0);
   endtask

   task automatic t_pause();
      do_clear();
      feed_word(8'hB7, 3, "R10");
      feed_word(8'h6D, 5, "R10");
      feed_word(8'h9E, 1, "R10");
      idle(1);
      feed_word(8'h00, 7, "R10");
   endtask

   task automatic t_clear_mid();
      do_clear();
      feed_word(8'h77, -1, "R5");
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         en = 1'b1;
         ser_in = 1'b1;
         @(posedge clk);
      end
      do_clear();
      check("R1", "acc after mid clear", 32'(acc), 32'd0);
      check("R1", "done after mid clear", 32'(word_done), 32'd0);
      feed_word(8'h11, -1, "R1");
      check("R1", "operand reg emptied", 32'(acc), 32'd0);
      feed_word(8'h00, -1, "R1");
      check("R3", "shifted sum", 32'(acc), 32'h11);
   endtask

   initial begin
      #1000000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_first_word();
      t_back_to_back();
      t_carry_boundary();
      t_pause();
      t_clear_mid();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule